// File: doc/BRIEF.md
# Sector Buffer Transfer Address Generator

This block turns a transfer request into the stream of buffer word addresses that a page load or page program walks through. The buffer has three regions of two sectors each: one boot region and two data regions. A sector holds 256 main words and 8 spare words. A request gives a 4-bit sector selector, a 1-bit sector count and a main/spare choice. The generator then emits one word address per accepted beat, running through one or two sectors of the chosen region.

The address stream uses valid/ready. `addr_valid` rises in the cycle after a start is accepted. While `addr_ready` is low, the current address stays on `addr` unchanged. A beat moves forward only in a cycle where both signals are high. The consumer may stall for any number of cycles. Over the whole transfer, `host_blk` marks which regions the host must not touch. `done` pulses once when the transfer ends. `err` pulses once when a request carries a selector code that names no region.

Top module: `sbuf_addr_gen`

## Requirements
- R1: Selector decoding uses three bits. Bit 3 = 0 picks the boot region (index 0). Bit 3 = 1 picks a data region: data region 0 (index 1) when bit 2 = 0, data region 1 (index 2) when bit 2 = 1. Bit 0 picks the sector within the region. In main mode the address is (2*index + sector)*256 + word.
- R2: In spare mode the address is 8000h + (2*index + sector)*8 + word. Word runs from 0 to 7.
- R3: A count input of 1 transfers one sector. A count input of 0 transfers two sectors.
- R4: In a two-sector transfer, the second sector is the other sector of the same region. Sector 1 wraps to sector 0, and the transfer never crosses into a neighbouring region.
- R5: Within a sector, words go out in ascending order from 0. The first address is valid in the cycle after start. While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr` does not change.
- R6: A selector with bit 1 set, or with bit 2 set and bit 3 clear, is invalid. One cycle after such a start, `err` pulses for exactly one cycle. No address is emitted and `done` does not pulse.
- R7: `done` is high for exactly one cycle: the cycle after the final beat is accepted. In that cycle `addr_valid` and `busy` are already low.
- R8: `host_blk` bit 0 is boot, bit 1 is data region 0, bit 2 is data region 1. During a boot or data-region-0 transfer it is 011b. During a data-region-1 transfer it is 100b. When idle it is 000b.
- R9: A start pulse that arrives while a transfer is in progress is ignored, and the running address sequence continues unchanged.
- R10: After reset, `addr_valid`, `done`, `err`, `busy` and `host_blk` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| sect_sel | input | 4 | Region and sector selector |
| one_sect | input | 1 | 1 = one sector, 0 = two sectors |
| spare_sel | input | 1 | 1 = spare-area addresses, 0 = main-area addresses |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | Address on `addr` is valid |
| addr | output | 16 | Buffer word address |
| done | output | 1 | One-cycle pulse after the last beat |
| err | output | 1 | One-cycle pulse for an invalid selector |
| busy | output | 1 | Transfer in progress |
| host_blk | output | 3 | Regions blocked for host access |

## Verification
A fault in the word counter, the sector toggle or the region register shows up right away as a wrong value on `addr`. The bench compares every beat of every valid selector, count and area combination, under an irregular ready pattern. A bad remaining-sector flag shows as `done` arriving 256 (or 8) beats early or late. A bad region decode shows on `host_blk` from the first beat. Faults in the idle-state gating show up at an ignored mid-transfer start or an invalid selector, within one cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    RGN_BOOT  = 2'd0,
    RGN_DATA0 = 2'd1,
    RGN_DATA1 = 2'd2
  } rgn_e;

  localparam int unsigned NUM_RGN = 3;
endpackage

// File: rtl/sbuf_decode.sv
module sbuf_decode
  import sbuf_pkg::*;
(
  input  logic [3:0] sel,
  output logic       ok,
  output rgn_e       rgn,
  output logic       sect
);
  always_comb begin
    ok   = !sel[1] && !(sel[2] && !sel[3]);
    sect = sel[0];
    if (!sel[3])     rgn = RGN_BOOT;
    else if (sel[2]) rgn = RGN_DATA1;
    else             rgn = RGN_DATA0;
  end
endmodule

// File: rtl/sbuf_addr_map.sv
module sbuf_addr_map #(
  parameter int unsigned MAIN_WORDS  = 256,
  parameter int unsigned SPARE_WORDS = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [15:0] SPARE_BASE  = 16'h8000,
  localparam int unsigned WORD_W     = $clog2(MAIN_WORDS)
) (
  input  logic [1:0]        rgn,
  input  logic              sect,
  input  logic              spare,
  input  logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] addr
);
  logic [2:0] slot;
  assign slot = {rgn, sect};

  always_comb begin
    if (spare)
      addr = ADDR_W'(SPARE_BASE) + ADDR_W'(slot) * ADDR_W'(SPARE_WORDS) + ADDR_W'(word);
    else
      addr = ADDR_W'(slot) * ADDR_W'(MAIN_WORDS) + ADDR_W'(word);
  end
endmodule

// File: rtl/sbuf_seq.sv
module sbuf_seq
  import sbuf_pkg::*;
#(
  parameter int unsigned MAIN_WORDS  = 256,
  parameter int unsigned SPARE_WORDS = 8,
  localparam int unsigned WORD_W     = $clog2(MAIN_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sel_ok,
  input  rgn_e              sel_rgn,
  input  logic              sel_sect,
  input  logic              one_sect,
  input  logic              spare_sel,
  input  logic              ready,
  output logic              run,
  output rgn_e              cur_rgn,
  output logic              cur_sect,
  output logic              cur_spare,
  output logic [WORD_W-1:0] word,
  output logic              done,
  output logic              err,
  output logic [NUM_RGN-1:0] host_blk
);
  logic              more_q;
  logic [WORD_W-1:0] last_word;

  assign last_word = cur_spare ? WORD_W'(SPARE_WORDS - 1) : WORD_W'(MAIN_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cur_rgn   <= RGN_BOOT;
      cur_sect  <= 1'b0;
      cur_spare <= 1'b0;
      more_q    <= 1'b0;
      word      <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!run) begin
        if (start) begin
          if (sel_ok) begin
            run       <= 1'b1;
            cur_rgn   <= sel_rgn;
            cur_sect  <= sel_sect;
            cur_spare <= spare_sel;
            more_q    <= !one_sect;
            word      <= '0;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (ready) begin
        if (word == last_word) begin
          word <= '0;
          if (more_q) begin
            more_q   <= 1'b0;
            cur_sect <= !cur_sect;
          end else begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          word <= word + 1'b1;
        end
      end
    end
  end

  // the other one of boot/data0 is blocked together with the active one
  always_comb begin
    host_blk = '0;
    if (run) begin
      if (cur_rgn == RGN_DATA1) host_blk[2] = 1'b1;
      else                      host_blk[1:0] = 2'b11;
    end
  end

  a_r7_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run && ready) && !run);
  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !run && !done);
  a_r8_blk_when_run: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> host_blk != '0);
  a_r9_rgn_held: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(cur_rgn) && $stable(cur_spare));
endmodule

// File: rtl/sbuf_addr_gen.sv
module sbuf_addr_gen
  import sbuf_pkg::*;
#(
  parameter int unsigned MAIN_WORDS  = 256,
  parameter int unsigned SPARE_WORDS = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [15:0] SPARE_BASE  = 16'h8000,
  localparam int unsigned WORD_W     = $clog2(MAIN_WORDS),
  localparam int unsigned MAIN_TOP   = NUM_RGN * 2 * MAIN_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        sect_sel,
  input  logic              one_sect,
  input  logic              spare_sel,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              err,
  output logic              busy,
  output logic [2:0]        host_blk
);
  logic              sel_ok, sel_sect, run, cur_sect, cur_spare;
  rgn_e              sel_rgn, cur_rgn;
  logic [WORD_W-1:0] word;

  sbuf_decode u_dec (
    .sel  (sect_sel),
    .ok   (sel_ok),
    .rgn  (sel_rgn),
    .sect (sel_sect)
  );

  sbuf_seq #(
    .MAIN_WORDS  (MAIN_WORDS),
    .SPARE_WORDS (SPARE_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sel_ok    (sel_ok),
    .sel_rgn   (sel_rgn),
    .sel_sect  (sel_sect),
    .one_sect  (one_sect),
    .spare_sel (spare_sel),
    .ready     (addr_ready),
    .run       (run),
    .cur_rgn   (cur_rgn),
    .cur_sect  (cur_sect),
    .cur_spare (cur_spare),
    .word      (word),
    .done      (done),
    .err       (err),
    .host_blk  (host_blk)
  );

  sbuf_addr_map #(
    .MAIN_WORDS  (MAIN_WORDS),
    .SPARE_WORDS (SPARE_WORDS),
    .ADDR_W      (ADDR_W),
    .SPARE_BASE  (SPARE_BASE)
  ) u_map (
    .rgn   (cur_rgn),
    .sect  (cur_sect),
    .spare (cur_spare),
    .word  (word),
    .addr  (addr)
  );

  assign addr_valid = run;
  assign busy       = run;

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr));
  a_r1_main_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr < ADDR_W'(SPARE_BASE) |-> addr < ADDR_W'(MAIN_TOP));
  a_r6_no_stream_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !addr_valid);
endmodule

// File: tb/sbuf_addr_gen_bench.sv
module sbuf_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  sect_sel = '0;
  logic        one_sect = 1'b0;
  logic        spare_sel = 1'b0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, done, err, busy;
  logic [15:0] addr;
  logic [2:0]  host_blk;
  logic [7:0]  lfsr = 8'h5a;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  sbuf_addr_gen u_sbuf_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sect_sel   (sect_sel),
    .one_sect   (one_sect),
    .spare_sel  (spare_sel),
    .addr_ready (addr_ready),
    .addr_valid (addr_valid),
    .addr       (addr),
    .done       (done),
    .err        (err),
    .busy       (busy),
    .host_blk   (host_blk)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (act %0d exp <150000 cycles)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [3:0] code, input logic c1, input logic sp, input bit poke);
    int rg, nsec, nw, ss;
    logic [15:0] exp;
    logic [2:0]  eblk;
    bit got;
    rg   = code[3] ? (code[2] ? 2 : 1) : 0;
    nsec = c1 ? 1 : 2;
    nw   = sp ? 8 : 256;
    eblk = (rg == 2) ? 3'b100 : 3'b011;
    @(negedge clk);
    start = 1'b1; sect_sel = code; one_sect = c1; spare_sel = sp;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nsec; k++) begin
      ss = (int'(code[0]) + k) % 2;   // R4 wrap inside region
      for (int w = 0; w < nw; w++) begin
        got = 1'b0;
        while (!got) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          addr_ready = lfsr[0] | lfsr[1];
          if (sp) exp = 16'(32'h8000 + (2*rg + ss)*8 + w);
          else    exp = 16'((2*rg + ss)*256 + w);
          chk(addr_valid === 1'b1, "R5 valid during transfer", 32'(addr_valid), 1);
          chk(addr === exp, sp ? "R2 R3 R4 spare address" : "R1 R3 R4 main address", 32'(addr), 32'(exp));
          chk(host_blk === eblk, "R8 host block", 32'(host_blk), 32'(eblk));
          if (poke && k == 0 && w == 3) begin
            start = 1'b1; sect_sel = 4'b1100; one_sect = 1'b1; spare_sel = ~sp; // R9
          end else begin
            start = 1'b0;
          end
          got = addr_ready;
          @(negedge clk);
        end
      end
    end
    start = 1'b0;
    addr_ready = 1'b0;
    chk(done === 1'b1, "R7 done pulse", 32'(done), 1);
    chk(addr_valid === 1'b0 && busy === 1'b0, "R7 idle with done", 32'({addr_valid, busy}), 0);
    chk(host_blk === 3'b000, "R8 idle unblocked", 32'(host_blk), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_valid === 1'b0 && done === 1'b0 && err === 1'b0 && busy === 1'b0 && host_blk === 3'b000,
        "R10 reset state", 32'({addr_valid, done, err, busy, host_blk}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      logic [3:0] cd;
      cd = 4'(c);
      if (cd[1] || (cd[2] && !cd[3])) begin
        @(negedge clk);
        start = 1'b1; sect_sel = cd; one_sect = 1'b0; spare_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(err === 1'b1 && addr_valid === 1'b0, "R6 error pulse", 32'({err, addr_valid}), 32'h2);
        @(negedge clk);
        chk(err === 1'b0 && addr_valid === 1'b0 && done === 1'b0, "R6 no stream", 32'({err, addr_valid, done}), 0);
      end
    end

    for (int c = 0; c < 16; c++) begin
      logic [3:0] cd;
      cd = 4'(c);
      if (!(cd[1] || (cd[2] && !cd[3]))) begin
        for (int m = 0; m < 4; m++) begin
          run_xfer(cd, m[0], m[1], (c == 9 && m == 0) || (c == 0 && m == 2));
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule